// File: doc/BRIEF.md
# Asynchronous NAND Strobe Timing Controller

This block turns single-byte requests from a local port into the pin-level cycles of an 8-bit asynchronous NAND flash device. A request says whether it is a read or a write and, for writes, whether the byte is a command, an address or plain data. The controller then drives chip enable, the write and read strobes, and the command and address latch lines in a fixed sequence of phases. The length of each phase comes from one 32-bit timing word.

Each access runs through up to four phases, in this order: an optional bus turnaround, setup, strobe and hold. Reads and writes each have their own setup, strobe and hold counts. Read data is captured on the last clock of the read strobe and returned as a one-cycle response. The device's ready/busy pin is brought into the clock domain and shown on bit 0 of a status output. The local port accepts a new request only while the controller is idle.

Top module: `nand_strobe_ctrl`

## Requirements
- R1: After reset, and whenever `req_ready` is high, `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1 and `nand_cle`, `nand_ale` and `nand_io_oe` are 0. `req_ready` is 1 after reset.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the last hold cycle of that access has completed.
- R3: For writes, `req_kind` 2'b01 (command) holds `nand_cle`=1 and `nand_ale`=0 while `nand_ce_n` is low, and 2'b10 (address) holds `nand_ale`=1 and `nand_cle`=0. The values 2'b00 and 2'b11 (data), and every read, keep both lines at 0.
- R4: A timing field value N lasts N+1 clocks. Writes use setup = bits [29:26], strobe = [25:20] and hold = [19:17]. Reads use setup = [16:13], strobe = [12:7] and hold = [6:4]. `nand_ce_n` is low for exactly the setup, strobe and hold cycles. The strobe line that matches the direction is low only during the strobe cycles, and the other strobe stays high.
- R5: During a write, `nand_io_oe` is 1 and `nand_io_out` equals the request byte for the whole time `nand_ce_n` is low. During a read, `nand_io_oe` stays 0.
- R6: For a read, `rsp_valid` pulses for exactly one clock, in the cycle after the last strobe cycle. `rsp_rdata` then holds the value that `nand_io_in` had during the last strobe cycle. Writes produce no response.
- R7: When an access's direction differs from the previous accepted access, the access starts with T+1 cycles in which `nand_ce_n` is high, where T = bits [3:2]. No such cycles are inserted for the first access after reset or when the direction repeats.
- R8: The timing word is sampled when the request is accepted. Changes to `cfg_word` during an access have no effect on that access. Bits [31:30] and [1:0] have no effect.
- R9: `dev_status[0]` shows `nand_rb` two clocks later (1 = device ready), and `dev_status[7:1]` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Packed timing word |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_kind | input | 2 | Write kind: 01 command, 10 address, 00/11 data |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 8 | Captured read byte |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_io_out | output | 8 | Data bus driven value |
| nand_io_oe | output | 1 | Data bus drive enable |
| nand_io_in | input | 8 | Data bus sampled value |
| nand_rb | input | 1 | Ready/busy pin, 1 = ready |
| dev_status | output | 8 | Bit 0 = synchronized device ready |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, a 32-bit timing word and a two-stage ready synchronizer. It also uses the full field widths, so every phase can run from 1 clock up to 64 clocks for the read and write strobes. Random timing words cover all setup, strobe, hold and turnaround values, including the all-zero and all-ones corners. Random direction sequences reach turnaround both when the direction changes and when it repeats. Changing the input bus value every cycle lets the bench pin down the exact capture clock for reads.

// File: rtl/nand_strobe_pkg.sv
package nand_strobe_pkg;

  localparam int CNT_W = 6;

  localparam int WSU_LSB = 26;
  localparam int WSU_W   = 4;
  localparam int WST_LSB = 20;
  localparam int WST_W   = 6;
  localparam int WHD_LSB = 17;
  localparam int WHD_W   = 3;
  localparam int RSU_LSB = 13;
  localparam int RSU_W   = 4;
  localparam int RST_LSB = 7;
  localparam int RST_W   = 6;
  localparam int RHD_LSB = 4;
  localparam int RHD_W   = 3;
  localparam int TA_LSB  = 2;
  localparam int TA_W    = 2;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_TURN   = 3'd1,
    PH_SETUP  = 3'd2,
    PH_STROBE = 3'd3,
    PH_HOLD   = 3'd4
  } phase_e;

  localparam logic [1:0] KIND_CMD  = 2'b01;
  localparam logic [1:0] KIND_ADDR = 2'b10;

  typedef struct packed {
    logic [CNT_W-1:0] turn;
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] strobe;
    logic [CNT_W-1:0] hold;
  } timing_t;

endpackage

// File: rtl/nand_cfg_decode.sv
module nand_cfg_decode
  import nand_strobe_pkg::*;
#(
  parameter int CFG_W = 32
) (
  input  logic [CFG_W-1:0] cfg,
  input  logic             is_write,
  output timing_t          tim
);

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg[CFG_W-1:WSU_LSB+WSU_W], cfg[TA_LSB-1:0]};

  always_comb begin
    tim.turn = CNT_W'(cfg[TA_LSB +: TA_W]);
    if (is_write) begin
      tim.setup  = CNT_W'(cfg[WSU_LSB +: WSU_W]);
      tim.strobe = CNT_W'(cfg[WST_LSB +: WST_W]);
      tim.hold   = CNT_W'(cfg[WHD_LSB +: WHD_W]);
    end else begin
      tim.setup  = CNT_W'(cfg[RSU_LSB +: RSU_W]);
      tim.strobe = CNT_W'(cfg[RST_LSB +: RST_W]);
      tim.hold   = CNT_W'(cfg[RHD_LSB +: RHD_W]);
    end
  end

endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
  import nand_strobe_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    need_turn,
  input  timing_t tim,
  output phase_e  phase,
  output logic    last_strobe
);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] limit;
  logic             at_limit;

  always_comb begin
    case (phase_q)
      PH_TURN:   limit = tim.turn;
      PH_SETUP:  limit = tim.setup;
      PH_STROBE: limit = tim.strobe;
      PH_HOLD:   limit = tim.hold;
      default:   limit = '0;
    endcase
  end

  assign at_limit = (cnt_q == limit);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = need_turn ? PH_TURN : PH_SETUP;
          cnt_d   = '0;
        end
      end
      default: begin
        if (at_limit) begin
          cnt_d = '0;
          case (phase_q)
            PH_TURN:   phase_d = PH_SETUP;
            PH_SETUP:  phase_d = PH_STROBE;
            PH_STROBE: phase_d = PH_HOLD;
            default:   phase_d = PH_IDLE;
          endcase
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase       = phase_q;
  assign last_strobe = (phase_q == PH_STROBE) && at_limit;

endmodule

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= pin;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], pin};
      end
    end
  endgenerate

  assign level = chain_q[STAGES-1];

endmodule

// File: rtl/nand_strobe_ctrl.sv
module nand_strobe_ctrl
  import nand_strobe_pkg::*;
#(
  parameter int IO_W        = 8,
  parameter int CFG_W       = 32,
  parameter int STAT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_kind,
  input  logic [IO_W-1:0]   req_wdata,
  output logic              rsp_valid,
  output logic [IO_W-1:0]   rsp_rdata,
  output logic              nand_ce_n,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic [IO_W-1:0]   nand_io_out,
  output logic              nand_io_oe,
  input  logic [IO_W-1:0]   nand_io_in,
  input  logic              nand_rb,
  output logic [STAT_W-1:0] dev_status
);

  logic [CFG_W-1:0] cfg_q;
  logic             wr_q;
  logic [1:0]       kind_q;
  logic [IO_W-1:0]  wdata_q;
  logic             prev_valid_q;
  logic             prev_wr_q;
  logic [IO_W-1:0]  rdata_q;
  logic             rsp_valid_q;

  logic    accept;
  logic    need_turn;
  logic    last_strobe;
  logic    cs_active;
  logic    rb_level;
  phase_e  phase;
  timing_t tim;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign need_turn = prev_valid_q && (prev_wr_q != req_write);

  // request capture, enabled by accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q        <= '0;
      wr_q         <= 1'b0;
      kind_q       <= '0;
      wdata_q      <= '0;
      prev_valid_q <= 1'b0;
      prev_wr_q    <= 1'b0;
    end else if (accept) begin
      cfg_q        <= cfg_word;
      wr_q         <= req_write;
      kind_q       <= req_kind;
      wdata_q      <= req_wdata;
      prev_valid_q <= 1'b1;
      prev_wr_q    <= req_write;
    end
  end

  // read capture, enabled on the last strobe clock of a read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (last_strobe && !wr_q) begin
      rdata_q <= nand_io_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid_q <= 1'b0;
    else        rsp_valid_q <= last_strobe && !wr_q;
  end

  nand_cfg_decode #(.CFG_W(CFG_W)) u_decode (
    .cfg      (cfg_q),
    .is_write (wr_q),
    .tim      (tim)
  );

  nand_phase_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .need_turn   (need_turn),
    .tim         (tim),
    .phase       (phase),
    .last_strobe (last_strobe)
  );

  nand_rb_sync #(.STAGES(SYNC_STAGES)) u_rb (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (nand_rb),
    .level (rb_level)
  );

  assign cs_active   = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign nand_ce_n   = !cs_active;
  assign nand_we_n   = !((phase == PH_STROBE) && wr_q);
  assign nand_re_n   = !((phase == PH_STROBE) && !wr_q);
  assign nand_cle    = cs_active && wr_q && (kind_q == KIND_CMD);
  assign nand_ale    = cs_active && wr_q && (kind_q == KIND_ADDR);
  assign nand_io_oe  = cs_active && wr_q;
  assign nand_io_out = wdata_q;
  assign rsp_valid   = rsp_valid_q;
  assign rsp_rdata   = rdata_q;
  assign dev_status  = {{(STAT_W-1){1'b0}}, rb_level};

endmodule

// File: rtl/nand_strobe_chk.sv
module nand_strobe_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic nand_ce_n,
  input logic nand_we_n,
  input logic nand_re_n,
  input logic nand_cle,
  input logic nand_ale,
  input logic nand_io_oe,
  input logic rsp_valid
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_io_oe));

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_latch_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  assert_strobe_in_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> (!nand_ce_n && (nand_we_n || nand_re_n)));

  assert_bus_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n |-> nand_io_oe) and (!nand_re_n |-> !nand_io_oe));

  assert_rsp_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (nand_re_n && $past(!nand_re_n)));

  assert_turn_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && nand_ce_n) |-> (nand_we_n && nand_re_n && !nand_io_oe));

endmodule

bind nand_strobe_ctrl nand_strobe_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .nand_ce_n  (nand_ce_n),
  .nand_we_n  (nand_we_n),
  .nand_re_n  (nand_re_n),
  .nand_cle   (nand_cle),
  .nand_ale   (nand_ale),
  .nand_io_oe (nand_io_oe),
  .rsp_valid  (rsp_valid)
);

// File: tb/tb_nand_strobe_ctrl.sv
`timescale 1ns/1ps
module tb_nand_strobe_ctrl;

  logic        clk;
  logic        rst_n;
  logic [31:0] cfg_word;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [1:0]  req_kind;
  logic [7:0]  req_wdata;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_io_oe;
  logic [7:0]  nand_io_out;
  logic [7:0]  nand_io_in;
  logic        nand_rb;
  logic [7:0]  dev_status;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 0;
  bit  prev_valid = 0;
  bit  prev_w     = 0;

  nand_strobe_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_kind(req_kind), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .nand_ce_n(nand_ce_n), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_io_out(nand_io_out),
    .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in), .nand_rb(nand_rb),
    .dev_status(dev_status)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int fld(input logic [31:0] c, input int lsb, input int w);
    return int'((c >> lsb) & ((32'd1 << w) - 1));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_access(input bit w, input logic [1:0] kind,
                           input logic [7:0] d, input logic [31:0] cfg);
    int  e_turn, e_su, e_st, e_hd;
    int  turn_n, su_n, st_n, hd_n, rsp_n;
    bit  seen_ce, lines_bad, data_bad, wrong_strobe, busy_bad;
    bit  e_cle, e_ale;
    logic [7:0] e_rd, got_rd;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cfg_word  = cfg;
    req_write = w;
    req_kind  = kind;
    req_wdata = d;
    req_valid = 1'b1;
    e_turn = (prev_valid && prev_w != w) ? fld(cfg, 2, 2) + 1 : 0;
    e_su = w ? fld(cfg, 26, 4) + 1 : fld(cfg, 13, 4) + 1;
    e_st = w ? fld(cfg, 20, 6) + 1 : fld(cfg, 7, 6) + 1;
    e_hd = w ? fld(cfg, 17, 3) + 1 : fld(cfg, 4, 3) + 1;
    e_cle = w && (kind == 2'b01);
    e_ale = w && (kind == 2'b10);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_word  = $urandom;   // R8: must not affect the running access
    turn_n = 0; su_n = 0; st_n = 0; hd_n = 0; rsp_n = 0;
    seen_ce = 0; lines_bad = 0; data_bad = 0; wrong_strobe = 0; busy_bad = 0;
    e_rd = 8'h00; got_rd = 8'h00;
    for (int i = 0; i < 400; i++) begin
      if (req_ready) break;
      if (rsp_valid) begin rsp_n++; got_rd = rsp_rdata; end
      nand_io_in = 8'($urandom);
      if (nand_ce_n) begin
        if (seen_ce) busy_bad = 1;
        turn_n++;
        if (nand_cle || nand_ale || nand_io_oe) lines_bad = 1;
      end else begin
        seen_ce = 1;
        if (nand_cle != e_cle || nand_ale != e_ale) lines_bad = 1;
        if (w && (!nand_io_oe || nand_io_out != d)) data_bad = 1;
        if (!w && nand_io_oe) data_bad = 1;
        if (!nand_we_n || !nand_re_n) begin
          st_n++;
          if (w ? (!nand_re_n || nand_we_n) : (!nand_we_n || nand_re_n)) wrong_strobe = 1;
          if (!nand_re_n) e_rd = nand_io_in;
        end else if (st_n == 0) su_n++;
        else hd_n++;
      end
      @(negedge clk);
    end
    chk(req_ready, "R2 access did not complete", int'(req_ready), 1);
    chk(!busy_bad, "R2 chip enable rose and fell again inside one access", int'(busy_bad), 0);
    chk(turn_n == e_turn, "R7 turnaround cycles", turn_n, e_turn);
    chk(su_n == e_su, "R4 setup cycles", su_n, e_su);
    chk(st_n == e_st, "R4 strobe cycles", st_n, e_st);
    chk(hd_n == e_hd, "R4 hold cycles", hd_n, e_hd);
    chk(!wrong_strobe, "R4 strobe line for direction", int'(wrong_strobe), 0);
    chk(!lines_bad, "R3 latch lines", int'(lines_bad), 0);
    chk(!data_bad, "R5 bus drive", int'(data_bad), 0);
    chk(rsp_n == (w ? 0 : 1), "R6 response pulses", rsp_n, w ? 0 : 1);
    if (!w) chk(got_rd == e_rd, "R6 read data", int'(got_rd), int'(e_rd));
    // R1 idle outputs after completion
    chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_io_oe,
        "R1 idle outputs", int'({nand_ce_n, nand_we_n, nand_re_n}), 7);
    prev_valid = 1;
    prev_w     = w;
  endtask

  localparam logic [31:0] CFG_TYP = (32'd1 << 26) | (32'd3 << 20) | (32'd1 << 17) |
                                    (32'd1 << 13) | (32'd5 << 7) | (32'd1 << 4) | (32'd3 << 2);

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          n_checks++;
          n_fail++;
          $display("FAIL R2 watchdog expired actual=0 expected=1");
          $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
          $finish;
        end
      end
    join_none
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 0; cfg_word = '0; req_valid = 0; req_write = 0; req_kind = 0;
    req_wdata = 0; nand_io_in = 0; nand_rb = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(nand_ce_n && nand_we_n && nand_re_n, "R1 strobes after reset",
        int'({nand_ce_n, nand_we_n, nand_re_n}), 7);
    chk(!nand_cle && !nand_ale && !nand_io_oe && !rsp_valid, "R1 lines after reset",
        int'({nand_cle, nand_ale, nand_io_oe, rsp_valid}), 0);

    // directed: first access after reset has no turnaround (R7), typical timing
    do_access(1'b1, 2'b01, 8'h70, CFG_TYP);
    do_access(1'b1, 2'b10, 8'h3c, CFG_TYP);           // same direction, R7 no gap
    do_access(1'b0, 2'b00, 8'h00, CFG_TYP);           // direction change, R7 gap
    do_access(1'b0, 2'b01, 8'h00, CFG_TYP);           // read ignores kind, R3
    do_access(1'b1, 2'b11, 8'ha5, 32'h0000_0000);     // all-zero fields, R4 R3
    do_access(1'b0, 2'b00, 8'h00, 32'hffff_ffff);     // all-ones fields, R4 R8
    do_access(1'b1, 2'b00, 8'h5a, 32'hffff_ffff);
    do_access(1'b1, 2'b10, 8'h01, 32'hc000_0003);     // only ignored bits set, R8

    // constrained random mix
    for (int k = 0; k < 250; k++) begin
      do_access(1'($urandom), 2'($urandom), 8'($urandom), $urandom);
    end

    // R9 device ready synchronization
    @(negedge clk);
    nand_rb = 1'b0;
    @(negedge clk);
    chk(dev_status[0] == 1'b1, "R9 ready after one clock still old", int'(dev_status[0]), 1);
    @(negedge clk);
    chk(dev_status[0] == 1'b0, "R9 busy after two clocks", int'(dev_status[0]), 0);
    nand_rb = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(dev_status == 8'h01, "R9 ready after two clocks, upper bits zero", int'(dev_status), 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule